// File: doc/BRIEF.md
# Time-of-Day Alarm and Host Liveness Supervisor

This block sits beside a real-time clock's counter chain and does two supervisory jobs. First, it watches the live hours, minutes and seconds counters and compares them against three alarm latches. On the seconds tick where all three agree, and only if software has enabled the alarm, it latches an alarm flag and pulls an active-low interrupt line. The flag and the interrupt stay asserted until the host reads the status register.

Second, it checks that the host is alive. When the watchdog enable bit of the interrupt control register is set, the host must open and close slave select at regular intervals without moving any serial data. If no such empty select period arrives within a parameterised number of cycles, the block drives an active-low CPU reset pulse of fixed length. It also sets a watchdog flag in the status register. The counter then starts over.

The counter values, the tick, the slave-select activity indications and the control register come in as plain inputs. The block produces the interrupt, the reset pulse and the status byte.

Top module: `alarm_wdog_supervisor`

## Requirements
- R1: An alarm fires only when the hours, minutes and seconds counters each equal their alarm latch; a difference in any single field at a tick leaves status bit 3 clear and intN high.
- R2: A tick (secTick high for one cycle) that finds a match while intCtrl bit 4 is 1 sets status bit 3 and drives intN low from the next cycle.
- R3: While intCtrl bit 4 is 0, a matching tick neither sets status bit 3 nor drives intN low.
- R4: The comparison is made only on a tick: a standing match without a tick, or after the flag was cleared, raises nothing.
- R5: A statusRead pulse clears status bits 3 and 6 and releases intN in the next cycle; a new alarm in the same cycle as the read wins and leaves bit 3 set.
- R6: While intCtrl bit 7 is 0, cpuRstN never goes low.
- R7: With intCtrl bit 7 set and no service, cpuRstN goes low for exactly PULSE_CYCLES consecutive cycles; after that the counter restarts, so falling edges of successive pulses lie TIMEOUT_CYCLES + PULSE_CYCLES cycles apart.
- R8: Every watchdog timeout sets status bit 6, visible by the first low cycle of cpuRstN.
- R9: A slave-select period (ssActive high, then low) during which xferSeen never pulses counts as service and restarts the timeout; service more often than TIMEOUT_CYCLES keeps cpuRstN high.
- R10: A slave-select period during which xferSeen pulses is not service and does not delay the timeout.
- R11: After reset, intN and cpuRstN are high and the status byte is zero; status bits other than 3 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse after the time counters advance |
| curSec | input | DW | Live seconds counter (BCD) |
| curMin | input | DW | Live minutes counter (BCD) |
| curHour | input | DW | Live hours counter (BCD plus mode bits) |
| almSec | input | DW | Seconds alarm latch |
| almMin | input | DW | Minutes alarm latch |
| almHour | input | DW | Hours alarm latch |
| intCtrl | input | 8 | Interrupt control register; bit 7 watchdog enable, bit 4 alarm enable |
| ssActive | input | 1 | Slave select currently asserted (1 = selected) |
| xferSeen | input | 1 | Pulse for each serial transfer while selected |
| statusRead | input | 1 | One-cycle pulse when the host reads the status register |
| intN | output | 1 | Active-low alarm interrupt |
| cpuRstN | output | 1 | Active-low CPU reset pulse |
| status | output | 8 | Status byte; bit 6 watchdog timeout, bit 3 alarm |

## Verification
The checker watches several properties on every cycle:
- every fall of intN traces back to an enabled tick that found all three fields equal;
- a read without a tick leaves the alarm bit clear;
- cpuRstN only falls while the watchdog is enabled, and the timeout flag is already up when it does;
- no low stretch of cpuRstN outlasts the pulse length.

Only the bench scenarios can show the rest:
- the exact pulse period;
- that empty select periods really hold off the reset while periods with a transfer do not;
- that a standing match raises one interrupt and no more.

// File: rtl/aws_pkg.sv
package aws_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic setAlarm;
    logic setWdog;
    logic clrFlags;
    logic startPulse;
    logic clrWdCnt;
    logic incWdCnt;
  } awsStrobe_t;

  // Conditions reported by the datapath to the control
  typedef struct packed {
    logic timeMatch;
    logic ssService;
    logic wdAtLimit;
    logic pulseLast;
  } awsCond_t;

  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_RUN   = 2'd1,
    WD_RESET = 2'd2
  } wdState_t;

  localparam int unsigned TIME_FIELDS = 3;
  localparam int unsigned WD_EN_BIT   = 7;
  localparam int unsigned AL_EN_BIT   = 4;
  localparam int unsigned ST_WD_BIT   = 6;
  localparam int unsigned ST_AL_BIT   = 3;

endpackage

// File: rtl/aws_datapath.sv
module aws_datapath
  import aws_pkg::*;
#(
  parameter int unsigned DW             = 8,
  parameter int unsigned TIMEOUT_CYCLES = 1000,
  parameter int unsigned PULSE_CYCLES   = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [TIME_FIELDS-1:0][DW-1:0]   curTime,
  input  logic [TIME_FIELDS-1:0][DW-1:0]   almTime,
  input  logic                             ssActive,
  input  logic                             xferSeen,
  input  awsStrobe_t                       strobe,
  output awsCond_t                         cond,
  output logic                             alarmFlag,
  output logic                             wdogFlag,
  output logic                             pulseActive
);

  localparam int unsigned CNT_W   = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam int unsigned PULSE_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0]   CNT_LIMIT = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [PULSE_W-1:0] PULSE_LOAD = PULSE_W'(PULSE_CYCLES);

  // Field-wise comparison of live time against alarm latches
  logic [TIME_FIELDS-1:0] fieldEq;
  for (genvar f = 0; f < TIME_FIELDS; f++) begin : gCmp
    assign fieldEq[f] = (curTime[f] == almTime[f]);
  end
  assign cond.timeMatch = &fieldEq;

  // Slave-select period tracking: a period is dirty once a transfer is seen
  logic ssPrev;
  logic ssDirty;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssPrev  <= 1'b0;
      ssDirty <= 1'b0;
    end else begin
      ssPrev <= ssActive;
      if (ssActive && !ssPrev)
        ssDirty <= xferSeen;
      else if (ssActive && xferSeen)
        ssDirty <= 1'b1;
    end
  end
  assign cond.ssService = ssPrev && !ssActive && !ssDirty;

  // Watchdog interval counter
  logic [CNT_W-1:0] wdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      wdCnt <= '0;
    else if (strobe.clrWdCnt)
      wdCnt <= '0;
    else if (strobe.incWdCnt)
      wdCnt <= wdCnt + 1'b1;
  end
  assign cond.wdAtLimit = (wdCnt == CNT_LIMIT);

  // Reset pulse length counter
  logic [PULSE_W-1:0] pulseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pulseCnt <= '0;
    else if (strobe.startPulse)
      pulseCnt <= PULSE_LOAD;
    else if (pulseCnt != '0)
      pulseCnt <= pulseCnt - 1'b1;
  end
  assign cond.pulseLast = (pulseCnt == PULSE_W'(1));
  assign pulseActive    = (pulseCnt != '0);

  // Status flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      wdogFlag  <= 1'b0;
    end else begin
      if (strobe.setAlarm)      alarmFlag <= 1'b1;
      else if (strobe.clrFlags) alarmFlag <= 1'b0;
      if (strobe.setWdog)       wdogFlag  <= 1'b1;
      else if (strobe.clrFlags) wdogFlag  <= 1'b0;
    end
  end

endmodule

// File: rtl/aws_control.sv
module aws_control
  import aws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       alarmEn,
  input  logic       wdogEn,
  input  logic       statusRead,
  input  awsCond_t   cond,
  output awsStrobe_t strobe
);

  wdState_t wdState, wdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wdState <= WD_OFF;
    else       wdState <= wdNext;
  end

  always_comb begin
    strobe          = '0;
    wdNext          = wdState;
    // Alarm is sampled only on the seconds tick
    strobe.setAlarm = secTick && alarmEn && cond.timeMatch;
    strobe.clrFlags = statusRead;

    unique case (wdState)
      WD_OFF: begin
        strobe.clrWdCnt = 1'b1;
        if (wdogEn) wdNext = WD_RUN;
      end
      WD_RUN: begin
        if (!wdogEn) begin
          strobe.clrWdCnt = 1'b1;
          wdNext          = WD_OFF;
        end else if (cond.ssService) begin
          strobe.clrWdCnt = 1'b1;
        end else if (cond.wdAtLimit) begin
          strobe.startPulse = 1'b1;
          strobe.setWdog    = 1'b1;
          strobe.clrWdCnt   = 1'b1;
          wdNext            = WD_RESET;
        end else begin
          strobe.incWdCnt = 1'b1;
        end
      end
      WD_RESET: begin
        strobe.clrWdCnt = 1'b1;
        if (cond.pulseLast) wdNext = wdogEn ? WD_RUN : WD_OFF;
      end
      default: begin
        strobe.clrWdCnt = 1'b1;
        wdNext          = WD_OFF;
      end
    endcase
  end

endmodule

// File: rtl/alarm_wdog_supervisor.sv
module alarm_wdog_supervisor
  import aws_pkg::*;
#(
  parameter int unsigned DW             = 8,
  parameter int unsigned TIMEOUT_CYCLES = 1000,
  parameter int unsigned PULSE_CYCLES   = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          secTick,
  input  logic [DW-1:0] curSec,
  input  logic [DW-1:0] curMin,
  input  logic [DW-1:0] curHour,
  input  logic [DW-1:0] almSec,
  input  logic [DW-1:0] almMin,
  input  logic [DW-1:0] almHour,
  input  logic [7:0]    intCtrl,
  input  logic          ssActive,
  input  logic          xferSeen,
  input  logic          statusRead,
  output logic          intN,
  output logic          cpuRstN,
  output logic [7:0]    status
);

  logic [TIME_FIELDS-1:0][DW-1:0] curTime;
  logic [TIME_FIELDS-1:0][DW-1:0] almTime;
  assign curTime = {curHour, curMin, curSec};
  assign almTime = {almHour, almMin, almSec};

  logic unusedCtrlBits;
  assign unusedCtrlBits = ^{intCtrl[6:5], intCtrl[3:0]};

  awsStrobe_t strobe;
  awsCond_t   cond;
  logic       alarmFlag;
  logic       wdogFlag;
  logic       pulseActive;

  aws_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .secTick    (secTick),
    .alarmEn    (intCtrl[AL_EN_BIT]),
    .wdogEn     (intCtrl[WD_EN_BIT]),
    .statusRead (statusRead),
    .cond       (cond),
    .strobe     (strobe)
  );

  aws_datapath #(
    .DW             (DW),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .PULSE_CYCLES   (PULSE_CYCLES)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .curTime     (curTime),
    .almTime     (almTime),
    .ssActive    (ssActive),
    .xferSeen    (xferSeen),
    .strobe      (strobe),
    .cond        (cond),
    .alarmFlag   (alarmFlag),
    .wdogFlag    (wdogFlag),
    .pulseActive (pulseActive)
  );

  assign intN    = !alarmFlag;
  assign cpuRstN = !pulseActive;

  always_comb begin
    status            = 8'h00;
    status[ST_WD_BIT] = wdogFlag;
    status[ST_AL_BIT] = alarmFlag;
  end

endmodule

// File: rtl/alarm_wdog_checker.sv
module alarm_wdog_checker #(
  parameter int unsigned DW           = 8,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          secTick,
  input logic [DW-1:0] curSec,
  input logic [DW-1:0] curMin,
  input logic [DW-1:0] curHour,
  input logic [DW-1:0] almSec,
  input logic [DW-1:0] almMin,
  input logic [DW-1:0] almHour,
  input logic [7:0]    intCtrl,
  input logic          statusRead,
  input logic          intN,
  input logic          cpuRstN,
  input logic [7:0]    status
);

  logic allEq;
  assign allEq = (curSec == almSec) && (curMin == almMin) && (curHour == almHour);

  int unsigned lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lowRun <= 0;
    else if (!cpuRstN) lowRun <= lowRun + 1;
    else               lowRun <= 0;
  end

  // R1: a falling interrupt needs all three fields equal at the prior edge
  a_r1_full_match: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(allEq));

  // R2: enabled matching tick pulls the interrupt low next cycle
  a_r2_alarm_raises: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && intCtrl[4] && allEq) |=> (!intN && status[3]));

  // R3 and R4: interrupt falls only after an enabled tick
  a_r4_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(secTick && intCtrl[4]));

  // R5: a read without a tick clears the alarm bit
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !secTick) |=> (!status[3] && intN));

  // R6: reset pulse only starts while the watchdog is enabled
  a_r6_wdog_gated: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuRstN) |-> $past(intCtrl[7]));

  // R7: no low stretch longer than the pulse length
  a_r7_pulse_bounded: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= PULSE_CYCLES);

  // R8: timeout flag is up when the pulse starts
  a_r8_flag_on_timeout: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuRstN) |-> status[6]);

  // R11: unused status bits stay zero
  a_r11_status_clean: assert property (@(posedge clk) disable iff (!rstN)
    (status & 8'hB7) == 8'h00);

endmodule

bind alarm_wdog_supervisor alarm_wdog_checker #(
  .DW           (DW),
  .PULSE_CYCLES (PULSE_CYCLES)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .secTick    (secTick),
  .curSec     (curSec),
  .curMin     (curMin),
  .curHour    (curHour),
  .almSec     (almSec),
  .almMin     (almMin),
  .almHour    (almHour),
  .intCtrl    (intCtrl),
  .statusRead (statusRead),
  .intN       (intN),
  .cpuRstN    (cpuRstN),
  .status     (status)
);

// File: tb/alarm_wdog_supervisor_test.sv
module alarm_wdog_supervisor_test;

  localparam int unsigned DW      = 8;
  localparam int unsigned TIMEOUT = 40;
  localparam int unsigned PULSE   = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          secTick = 1'b0;
  logic [DW-1:0] curSec = '0, curMin = '0, curHour = '0;
  logic [DW-1:0] almSec = '0, almMin = '0, almHour = '0;
  logic [7:0]    intCtrl = 8'h00;
  logic          ssActive = 1'b0, xferSeen = 1'b0, statusRead = 1'b0;
  logic          intN, cpuRstN;
  logic [7:0]    status;

  int checks = 0;
  int errors = 0;
  int lowCount = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alarm_wdog_supervisor #(
    .DW(DW), .TIMEOUT_CYCLES(TIMEOUT), .PULSE_CYCLES(PULSE)
  ) uut (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .almSec(almSec), .almMin(almMin), .almHour(almHour),
    .intCtrl(intCtrl), .ssActive(ssActive), .xferSeen(xferSeen),
    .statusRead(statusRead), .intN(intN), .cpuRstN(cpuRstN), .status(status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance one cycle, sample at the falling edge, count reset-low cycles
  task automatic step();
    @(negedge clk);
    if (!cpuRstN) lowCount++;
  endtask

  // {reqId[3:0], cur hh:mm:ss[23:0], alm hh:mm:ss[23:0], en, tick, read, expIntN, expAlarmBit}
  localparam int NV = 13;
  localparam logic [56:0] VEC [NV] = '{
    {4'd2, 24'h123456, 24'h123456, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 match raises
    {4'd5, 24'h123456, 24'h123456, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 read clears
    {4'd4, 24'h123456, 24'h123456, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 standing match, no tick
    {4'd1, 24'h123457, 24'h123456, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R1 seconds differ
    {4'd1, 24'h123556, 24'h123456, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R1 minutes differ
    {4'd1, 24'h113456, 24'h123456, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R1 hours differ
    {4'd3, 24'h123456, 24'h123456, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 disabled
    {4'd4, 24'h123456, 24'h123456, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 no tick
    {4'd5, 24'h123456, 24'h123456, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 set wins over read
    {4'd2, 24'h235959, 24'h235959, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 stays set
    {4'd5, 24'h235959, 24'h235959, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 read clears
    {4'd2, 24'h000000, 24'h000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 midnight
    {4'd5, 24'h000000, 24'h000000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}  // R5 read clears
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b, len;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 intN", intN, 1);
    check("R11 cpuRstN", cpuRstN, 1);
    check("R11 status", status, 0);

    // Alarm vector table
    for (int i = 0; i < NV; i++) begin
      {curHour, curMin, curSec} = VEC[i][52:29];
      {almHour, almMin, almSec} = VEC[i][28:5];
      intCtrl    = {3'b000, VEC[i][4], 4'b0000};
      secTick    = VEC[i][3];
      statusRead = VEC[i][2];
      @(negedge clk);
      secTick    = 1'b0;
      statusRead = 1'b0;
      check($sformatf("R%0d vec %0d intN", VEC[i][56:53], i), intN, VEC[i][1]);
      check($sformatf("R%0d vec %0d status[3]", VEC[i][56:53], i), status[3], VEC[i][0]);
    end
    intCtrl = 8'h00;

    // R6: watchdog disabled, no pulse
    lowCount = 0;
    repeat (3 * TIMEOUT) step();
    check("R6 low cycles while disabled", lowCount, 0);

    // R7/R8: unserviced watchdog
    intCtrl = 8'h80;
    a = -1; b = -1; len = 0;
    for (int c = 0; c < 4 * (TIMEOUT + PULSE); c++) begin
      @(negedge clk);
      if (!cpuRstN) begin
        if (a < 0) a = c;
        else if (b < 0 && c > a + int'(PULSE) + 1) b = c;
        if (b < 0) len++;
      end
      if (a == c) check("R8 status[6] at pulse", status[6], 1);
      if (b >= 0) break;
    end
    check("R7 pulse length", len, PULSE);
    check("R7 pulse period", b - a, TIMEOUT + PULSE);
    intCtrl = 8'h00;
    repeat (PULSE + 2) @(negedge clk);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    check("R5 read clears status[6]", status[6], 0);
    check("R11 reserved status bits", status & 8'hB7, 0);

    // R9: empty select periods keep the watchdog quiet
    repeat (4) @(negedge clk);
    intCtrl = 8'h80;
    lowCount = 0;
    for (int k = 0; k < 12; k++) begin
      ssActive = 1'b1;
      repeat (2) step();
      ssActive = 1'b0;
      repeat (16) step();
    end
    check("R9 low cycles with service", lowCount, 0);
    check("R9 status[6] with service", status[6], 0);

    // R10: select periods with a transfer do not service
    lowCount = 0;
    for (int k = 0; k < 12; k++) begin
      ssActive = 1'b1;
      step();
      xferSeen = 1'b1;
      step();
      xferSeen = 1'b0;
      ssActive = 1'b0;
      repeat (16) step();
    end
    check("R10 pulse despite busy selects", (lowCount > 0) ? 1 : 0, 1);
    check("R10 status[6] after timeout", status[6], 1);
    intCtrl = 8'h00;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule